// File: doc/BRIEF.md
# Receive Frame Header Checker

This block inspects the frame at the front of a receive queue held in a MAC packet buffer. On a start strobe it first looks at a queue-empty flag. If the queue holds a frame, the block reads two 16-bit words from the front of that frame through a simple memory read port. The word at offset 0 is the frame status. The word at offset 1 is the stored byte count.

The block then classifies the frame. A frame is rejected if any error bit in a fixed status mask is set, or if the byte count falls outside a fixed window. For an accepted frame it reports the usable length, which is the byte count less a fixed adjustment. In either case it sends a release-top-of-queue command to the buffer manager, so that the next frame moves to the front.

A controller uses it by pulsing start and then waiting for the one-cycle done pulse. On that pulse it reads good, bad and length. A done pulse with neither good nor bad set means the queue was empty.

Top module: `rx_head_check`

## Requirements
- R1: After reset, done, good, bad, rel_valid and mem_rd are all low, and len and rel_cmd are zero.
- R2: A start while q_empty is high gives done one cycle after the start cycle, with good=0, bad=0 and len=0. It issues no memory read and no release.
- R3: For a non-empty queue, the block issues exactly two one-cycle reads: the first at address 0 (status), the second at address 1 (byte count). It latches each word only when mem_valid is high, whatever the read latency.
- R4: The frame is bad when (status & 16'hAC00) is non-zero.
- R5: The frame is bad when the byte count is below 66 or above 1524. The counts 66 and 1524 are themselves accepted.
- R6: On done, a good frame reports len = count - 3. A bad frame reports len = 0.
- R7: For both good and bad frames, rel_valid pulses for one cycle together with done. While rel_valid is high, rel_cmd carries 8'h80, which is release code 4 in bits 7:5 and zeros elsewhere.
- R8: done lasts exactly one cycle, and good and bad are never high together. A start that arrives while a check is in progress is ignored: it produces no second done and no extra reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a header check (ignored while busy) |
| q_empty | input | 1 | Receive queue is empty |
| mem_rd | output | 1 | One-cycle buffer read request |
| mem_addr | output | 11 | Buffer word address of the read |
| mem_data | input | 16 | Read data from the buffer |
| mem_valid | input | 1 | mem_data holds the requested word |
| rel_valid | output | 1 | Release command strobe |
| rel_cmd | output | 8 | Command byte for the buffer manager |
| done | output | 1 | Result strobe |
| good | output | 1 | Frame accepted (valid with done) |
| bad | output | 1 | Frame rejected (valid with done) |
| len | output | 16 | Usable length of a good frame (valid with done) |

## Verification
The assertions assume that mem_valid rises only in answer to an outstanding read, and that each read gets exactly one mem_valid. The bench memory model guarantees this: it answers each mem_rd once, after a programmed latency of one to three cycles. It never raises mem_valid on its own. Start is driven for a single cycle. An extra start is injected mid-check only to test that it is ignored.

// File: rtl/rxhc_pkg.sv
package rxhc_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_STAT = 2'd1,
    S_CNT  = 2'd2,
    S_FIN  = 2'd3
  } hc_state_t;

  localparam logic [2:0] REL_CODE = 3'd4;
  localparam logic [7:0] REL_BYTE = {REL_CODE, 5'b0};
endpackage

// File: rtl/rxhc_classify.sv
module rxhc_classify #(
  parameter int DW        = 16,
  parameter int STAT_MASK = 16'hAC00,
  parameter int MIN_CNT   = 66,
  parameter int MAX_CNT   = 1524,
  parameter int LEN_ADJ   = 3
) (
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] cnt,
  output logic          ok,
  output logic [DW-1:0] len
);
  localparam logic [DW-1:0] MASK_V = DW'(STAT_MASK);
  localparam logic [DW-1:0] MIN_V  = DW'(MIN_CNT);
  localparam logic [DW-1:0] MAX_V  = DW'(MAX_CNT);
  localparam logic [DW-1:0] ADJ_V  = DW'(LEN_ADJ);

  logic err_bits, out_of_win;

  always_comb begin
    err_bits   = |(stat & MASK_V);
    out_of_win = (cnt < MIN_V) || (cnt > MAX_V);
    ok         = !err_bits && !out_of_win;
    len        = ok ? (cnt - ADJ_V) : '0;
  end
endmodule

// File: rtl/rxhc_seq.sv
module rxhc_seq
  import rxhc_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          q_empty,
  input  logic [DW-1:0] mem_data,
  input  logic          mem_valid,
  input  logic          cls_ok,
  input  logic [DW-1:0] cls_len,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] cnt_q,
  output logic          done,
  output logic          good,
  output logic          bad,
  output logic [DW-1:0] len,
  output logic          rel_valid,
  output logic [7:0]    rel_cmd
);
  localparam logic [AW-1:0] STAT_OFS = '0;
  localparam logic [AW-1:0] CNT_OFS  = AW'(1);

  hc_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      stat_q    <= '0;
      cnt_q     <= '0;
      done      <= 1'b0;
      good      <= 1'b0;
      bad       <= 1'b0;
      len       <= '0;
      rel_valid <= 1'b0;
      rel_cmd   <= '0;
    end else begin
      mem_rd    <= 1'b0;
      done      <= 1'b0;
      good      <= 1'b0;
      bad       <= 1'b0;
      len       <= '0;
      rel_valid <= 1'b0;
      rel_cmd   <= '0;
      unique case (st)
        S_IDLE: if (start) begin
          if (q_empty) begin
            done <= 1'b1;
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= STAT_OFS;
            st       <= S_STAT;
          end
        end
        S_STAT: if (mem_valid) begin
          stat_q   <= mem_data;
          mem_rd   <= 1'b1;
          mem_addr <= CNT_OFS;
          st       <= S_CNT;
        end
        S_CNT: if (mem_valid) begin
          cnt_q <= mem_data;
          st    <= S_FIN;
        end
        S_FIN: begin
          done      <= 1'b1;
          good      <= cls_ok;
          bad       <= !cls_ok;
          len       <= cls_len;
          rel_valid <= 1'b1;
          rel_cmd   <= REL_BYTE;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: read strobes are single-cycle
  p_rd_single_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  // R8: done is a one-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: verdicts exclusive
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(good && bad));
  // R7: release comes only with done and carries code 4
  p_rel_done_r7: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (done && rel_cmd[7:5] == REL_CODE && rel_cmd[4:0] == 5'd0));
  // R7: every verdict is accompanied by a release
  p_verdict_rel_r7: assert property (@(posedge clk) disable iff (rst)
    (good || bad) |-> rel_valid);
  // R2: an empty report issues no release
  p_empty_norel_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !good && !bad) |-> !rel_valid);
endmodule

// File: rtl/rx_head_check.sv
module rx_head_check #(
  parameter int AW        = 11,
  parameter int DW        = 16,
  parameter int STAT_MASK = 16'hAC00,
  parameter int MIN_CNT   = 66,
  parameter int MAX_CNT   = 1524,
  parameter int LEN_ADJ   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          q_empty,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  input  logic          mem_valid,
  output logic          rel_valid,
  output logic [7:0]    rel_cmd,
  output logic          done,
  output logic          good,
  output logic          bad,
  output logic [DW-1:0] len
);
  logic [DW-1:0] stat_q, cnt_q, cls_len;
  logic          cls_ok;

  rxhc_classify #(
    .DW(DW), .STAT_MASK(STAT_MASK), .MIN_CNT(MIN_CNT),
    .MAX_CNT(MAX_CNT), .LEN_ADJ(LEN_ADJ)
  ) u_cls (
    .stat(stat_q), .cnt(cnt_q), .ok(cls_ok), .len(cls_len)
  );

  rxhc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .q_empty(q_empty),
    .mem_data(mem_data), .mem_valid(mem_valid),
    .cls_ok(cls_ok), .cls_len(cls_len),
    .mem_rd(mem_rd), .mem_addr(mem_addr),
    .stat_q(stat_q), .cnt_q(cnt_q),
    .done(done), .good(good), .bad(bad), .len(len),
    .rel_valid(rel_valid), .rel_cmd(rel_cmd)
  );

  // R6: a good verdict never reports a length below the window minus the adjustment
  p_good_len_r6: assert property (@(posedge clk) disable iff (rst)
    good |-> (len >= DW'(MIN_CNT - LEN_ADJ)));
  // R6: a bad verdict reports zero length
  p_bad_len_r6: assert property (@(posedge clk) disable iff (rst)
    bad |-> (len == '0));
endmodule

// File: tb/tb_rx_head_check.sv
module tb_rx_head_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        q_empty = 1'b0;
  logic        mem_rd;
  logic [10:0] mem_addr;
  logic [15:0] mem_data = '0;
  logic        mem_valid = 1'b0;
  logic        rel_valid, done, good, bad;
  logic [7:0]  rel_cmd;
  logic [15:0] len;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  logic [10:0] addr_log [2];
  logic [15:0] stat_w = '0, cnt_w = '0;
  int lat = 1;
  int pend = 0;
  logic [10:0] paddr = '0;

  always #10 clk = ~clk;

  rx_head_check dut (
    .clk(clk), .rst(rst), .start(start), .q_empty(q_empty),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_valid(mem_valid), .rel_valid(rel_valid), .rel_cmd(rel_cmd),
    .done(done), .good(good), .bad(bad), .len(len)
  );

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_rd) begin
      if (rd_cnt < 2) addr_log[rd_cnt] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
      pend   <= lat;
      paddr  <= mem_addr;
    end else if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_valid <= 1'b1;
        mem_data  <= (paddr == 11'd0) ? stat_w : cnt_w;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] s, input logic [15:0] c, input int l,
                     input bit empty, input bit poke);
    bit exp_bad;
    int dc0;
    int waited;
    stat_w = s; cnt_w = c; lat = l; q_empty = empty;
    rd_cnt = 0;
    exp_bad = ((s & 16'hAC00) != 0) || (c < 66) || (c > 1524);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    dc0 = done_cnt;
    if (poke && !done) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    waited = 0;
    while (!done && waited < 50) begin @(negedge clk); waited++; end
    if (!done) begin
      chk(0, "R8 done timeout", 0, 1);
      return;
    end
    if (empty) begin
      chk(!good && !bad, "R2 no verdict", {good, bad}, 0);
      chk(len == 0, "R2 len", len, 0);
      chk(!rel_valid, "R2 no release", rel_valid, 0);
      chk(rd_cnt == 0, "R2 no reads", rd_cnt, 0);
    end else begin
      chk(rd_cnt == 2, "R3 read count", rd_cnt, 2);
      chk(addr_log[0] == 0 && addr_log[1] == 1, "R3 addresses",
          {addr_log[0], addr_log[1]}, 1);
      chk(bad == exp_bad && good == !exp_bad, "R4/R5 verdict (R4 R5)", {good, bad},
          {!exp_bad, exp_bad});
      chk(len == (exp_bad ? 16'd0 : c - 16'd3), "R6 length", len,
          exp_bad ? 0 : c - 3);
      chk(rel_valid && rel_cmd == 8'h80, "R7 release", {rel_valid, rel_cmd}, 'h180);
    end
    @(negedge clk);
    chk(!done && !rel_valid, "R8 one-cycle done", {done, rel_valid}, 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == dc0 + 1, "R8 single done", done_cnt - dc0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !good && !bad && !rel_valid && !mem_rd && len == 0 && rel_cmd == 0,
        "R1 reset state", {done, good, bad, rel_valid, mem_rd}, 0);
    run(16'h0000, 16'd200, 1, 1'b1, 1'b0);          // R2
    run(16'h0000, 16'd200, 1, 1'b0, 1'b0);          // R3 R6
    for (int c = 60; c <= 72; c++)                  // R5 low edge
      run(16'h0000, 16'(c), (c % 3) + 1, 1'b0, 1'b0);
    for (int c = 1518; c <= 1530; c++)              // R5 high edge
      run(16'h0000, 16'(c), (c % 3) + 1, 1'b0, 1'b0);
    for (int b = 0; b < 16; b++)                    // R4 each status bit
      run(16'(1 << b), 16'd500, (b % 3) + 1, 1'b0, 1'b0);
    run(16'hFFFF, 16'd30, 2, 1'b0, 1'b0);           // R4 R5 both
    run(16'h0000, 16'd1000, 3, 1'b0, 1'b1);         // R8 start while busy
    run(16'h0400, 16'd1000, 2, 1'b0, 1'b1);         // R8 R7 bad + poke
    run(16'h0000, 16'd64, 1, 1'b1, 1'b0);           // R2 again
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule